// File: doc/BRIEF.md
# PCI Target Configuration Header Registers

This block holds the type 0 configuration header of a simple PCI target function. The surrounding target logic gives it the latched low address byte, the decoded bus command, the active-low byte enables, the write data, and the IRDY#/TRDY# handshake. Only three doublewords hold writable state:

- the Command word, in which only memory space enable and parity error response are stored;
- one 32-bit memory Base Address Register, whose size is set by a parameter;
- the Interrupt Line byte.

A register is updated only in a clock where a configuration write data phase completes. The enabled byte lanes decide which bytes change.

Identity fields come from parameters: vendor, device, revision, class, header type, subsystem IDs, interrupt pin, minimum grant and maximum latency. A combinational multiplexer indexed by the doubleword number returns read data whenever the command is a configuration read. Every offset without a defined field reads as zero.

Top module: `pci_cfg_space`

## Requirements
- R1: After rst_ni is asserted, the Command word, the BAR and the Interrupt Line all read back as zero.
- R2: rdata_o carries header data only while cmd_i equals 4'b1010 (configuration read). For every other command it is 32'h0.
- R3: State changes only on a rising clk_i where cmd_i equals 4'b1011 (configuration write) and both irdy_ni and trdy_ni are low. In any other clock, including memory or I/O writes, all readable state holds.
- R4: be_ni[k] low enables byte lane k (data bits 8k+7..8k) of a write, and be_ni[k] high keeps that byte unchanged.
- R5: At offset 0x04, only bit 1 (memory space enable) and bit 6 (parity error response) are stored. All other Command bits and the Status half, bits 31..16, read as zero.
- R6: At offset 0x10, bits [BAR_SIZE_LOG2-1:0] always read zero, so the region is memory space, 32-bit and not prefetchable. Bits [31:BAR_SIZE_LOG2] store the written data.
- R7: At offset 0x3C, only bits 7..0 (Interrupt Line) are writable. Bits 15..8 read INT_PIN, bits 23..16 read MIN_GNT and bits 31..24 read MAX_LAT.
- R8: Identity words read back as follows:
  - 0x00 reads {DEVICE_ID, VENDOR_ID}.
  - 0x08 reads {CLASS_CODE, REVISION_ID}.
  - 0x0C reads {8'h00, HEADER_TYPE, 16'h0000}.
  - 0x2C reads {SUBSYS_ID, SUBSYS_VID}.
- R9: All other doubleword offsets in 0x00..0xFF read 32'h0, and a completed write to them leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_i | input | 8 | Latched configuration byte address |
| cmd_i | input | 4 | Decoded bus command |
| be_ni | input | 4 | Byte enables, active low, one per lane |
| irdy_ni | input | 1 | Initiator ready, active low |
| trdy_ni | input | 1 | Target ready, active low |
| wdata_i | input | 32 | Write data of the data phase |
| rdata_o | output | 32 | Read data during configuration reads |

## Verification
The hardest case to reach is a write with the right command and a writable offset that still must not commit, because one of the two handshake lines is high. The same applies to partial byte-enable patterns that change only some bits of the BAR or the Command word. The stimulus draws command, both ready lines, byte enables and offset independently from a seeded generator, so many near-miss writes occur. After each attempt, a configuration read of a random offset compares the whole visible header against a bench model. Directed cases cover an all-ones BAR write, a write to the Interrupt Pin byte, and reads under non-configuration commands.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_BAR  = 8'h10;
  localparam logic [7:0] OFS_INTR = 8'h3C;

  localparam logic [5:0] DW_ID    = 6'h00;
  localparam logic [5:0] DW_CMD   = 6'h01;
  localparam logic [5:0] DW_CLASS = 6'h02;
  localparam logic [5:0] DW_HDR   = 6'h03;
  localparam logic [5:0] DW_BAR   = 6'h04;
  localparam logic [5:0] DW_SUB   = 6'h0B;
  localparam logic [5:0] DW_INTR  = 6'h0F;

  // stored command bits: memory space enable, parity error response
  localparam logic [15:0] CMD_KEEP = 16'h0042;

  typedef struct packed {
    logic cmd;
    logic bar;
    logic intr;
  } wr_sel_t;
endpackage

// File: rtl/pci_cfg_wr_decode.sv
module pci_cfg_wr_decode
  import pci_cfg_pkg::*;
(
  input  logic [7:0] addr_i,
  input  logic [3:0] cmd_i,
  input  logic       irdy_ni,
  input  logic       trdy_ni,
  output wr_sel_t    sel_o
);
  logic phase_done;

  assign phase_done = (cmd_i == CMD_CFG_WR) && !irdy_ni && !trdy_ni;

  always_comb begin
    sel_o = '0;
    if (phase_done) begin
      unique case (addr_i)
        OFS_CMD:  sel_o.cmd  = 1'b1;
        OFS_BAR:  sel_o.bar  = 1'b1;
        OFS_INTR: sel_o.intr = 1'b1;
        default:  sel_o      = '0;
      endcase
    end
  end
endmodule

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
  import pci_cfg_pkg::*;
#(
  parameter int unsigned BAR_SIZE_LOG2 = 12,
  parameter int unsigned LANES         = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  wr_sel_t            sel_i,
  input  logic [LANES-1:0]   be_ni,
  input  logic [8*LANES-1:0] wdata_i,
  output logic [15:0]        cmd_o,
  output logic [8*LANES-1:0] bar_o,
  output logic [7:0]         int_line_o
);
  localparam int unsigned W = 8 * LANES;
  localparam logic [W-1:0] BAR_MASK = {W{1'b1}} << BAR_SIZE_LOG2;

  logic [7:0]   cmd_lo_q;
  logic [W-1:0] bar_q;
  logic [7:0]   int_line_q;

  // command: only lane 0 carries stored bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cmd_lo_q <= '0;
    else if (sel_i.cmd && !be_ni[0]) cmd_lo_q <= wdata_i[7:0] & CMD_KEEP[7:0];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_bar_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     bar_q[8*b +: 8] <= '0;
      else if (sel_i.bar && !be_ni[b]) bar_q[8*b +: 8] <= wdata_i[8*b +: 8] & BAR_MASK[8*b +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      int_line_q <= '0;
    else if (sel_i.intr && !be_ni[0]) int_line_q <= wdata_i[7:0];
  end

  assign cmd_o      = {8'h00, cmd_lo_q};
  assign bar_o      = bar_q;
  assign int_line_o = int_line_q;
endmodule

// File: rtl/pci_cfg_rd_mux.sv
module pci_cfg_rd_mux
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID   = 16'h3C4D,
  parameter logic [23:0] CLASS_CODE  = 24'h118000,
  parameter logic [7:0]  REVISION_ID = 8'h05,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [15:0] SUBSYS_ID   = 16'h0101,
  parameter logic [15:0] SUBSYS_VID  = 16'h1A2B,
  parameter logic [7:0]  INT_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GNT     = 8'h02,
  parameter logic [7:0]  MAX_LAT     = 8'h04
) (
  input  logic [5:0]  dw_i,
  input  logic        rd_en_i,
  input  logic [15:0] cmd_i,
  input  logic [31:0] bar_i,
  input  logic [7:0]  int_line_i,
  output logic [31:0] rdata_o
);
  logic [31:0] word;

  always_comb begin
    unique case (dw_i)
      DW_ID:    word = {DEVICE_ID, VENDOR_ID};
      DW_CMD:   word = {16'h0000, cmd_i};
      DW_CLASS: word = {CLASS_CODE, REVISION_ID};
      DW_HDR:   word = {8'h00, HEADER_TYPE, 16'h0000};
      DW_BAR:   word = bar_i;
      DW_SUB:   word = {SUBSYS_ID, SUBSYS_VID};
      DW_INTR:  word = {MAX_LAT, MIN_GNT, INT_PIN, int_line_i};
      default:  word = 32'h0;
    endcase
  end

  assign rdata_o = rd_en_i ? word : 32'h0;
endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
  import pci_cfg_pkg::*;
#(
  parameter int unsigned BAR_SIZE_LOG2 = 12,
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
  parameter logic [23:0] CLASS_CODE    = 24'h118000,
  parameter logic [7:0]  REVISION_ID   = 8'h05,
  parameter logic [7:0]  HEADER_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_ID     = 16'h0101,
  parameter logic [15:0] SUBSYS_VID    = 16'h1A2B,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h02,
  parameter logic [7:0]  MAX_LAT       = 8'h04
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  cfg_addr_i,
  input  logic [3:0]  cmd_i,
  input  logic [3:0]  be_ni,
  input  logic        irdy_ni,
  input  logic        trdy_ni,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  wr_sel_t     wr_sel;
  logic [15:0] cmd_word;
  logic [31:0] bar_word;
  logic [7:0]  int_line;

  pci_cfg_wr_decode u_dec (
    .addr_i (cfg_addr_i),
    .cmd_i  (cmd_i),
    .irdy_ni(irdy_ni),
    .trdy_ni(trdy_ni),
    .sel_o  (wr_sel)
  );

  pci_cfg_regs #(
    .BAR_SIZE_LOG2(BAR_SIZE_LOG2),
    .LANES        (4)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (wr_sel),
    .be_ni     (be_ni),
    .wdata_i   (wdata_i),
    .cmd_o     (cmd_word),
    .bar_o     (bar_word),
    .int_line_o(int_line)
  );

  pci_cfg_rd_mux #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .CLASS_CODE (CLASS_CODE),
    .REVISION_ID(REVISION_ID),
    .HEADER_TYPE(HEADER_TYPE),
    .SUBSYS_ID  (SUBSYS_ID),
    .SUBSYS_VID (SUBSYS_VID),
    .INT_PIN    (INT_PIN),
    .MIN_GNT    (MIN_GNT),
    .MAX_LAT    (MAX_LAT)
  ) u_rd (
    .dw_i      (cfg_addr_i[7:2]),
    .rd_en_i   (cmd_i == CMD_CFG_RD),
    .cmd_i     (cmd_word),
    .bar_i     (bar_word),
    .int_line_i(int_line),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/pci_cfg_space_chk.sv
module pci_cfg_space_chk #(
  parameter int unsigned BAR_SIZE_LOG2 = 12
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  cfg_addr_i,
  input logic [3:0]  cmd_i,
  input logic        irdy_ni,
  input logic        trdy_ni,
  input logic [31:0] rdata_o,
  input logic [15:0] cmd_word,
  input logic [31:0] bar_word,
  input logic [7:0]  int_line
);
  logic done;
  logic hit;
  assign done = (cmd_i == 4'b1011) && !irdy_ni && !trdy_ni;
  assign hit  = (cfg_addr_i == 8'h04) || (cfg_addr_i == 8'h10) || (cfg_addr_i == 8'h3C);

  // R2
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != 4'b1010) |-> (rdata_o == 32'h0));

  // R3
  no_phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> ($stable(cmd_word) && $stable(bar_word) && $stable(int_line)));

  // R9
  other_ofs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !hit) |=> ($stable(cmd_word) && $stable(bar_word) && $stable(int_line)));

  // R5
  cmd_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'b1010 && cfg_addr_i == 8'h04) |-> ((rdata_o & ~32'h0000_0042) == 32'h0));

  // R6
  bar_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'b1010 && cfg_addr_i == 8'h10) |-> (rdata_o[BAR_SIZE_LOG2-1:0] == '0));
endmodule

bind pci_cfg_space pci_cfg_space_chk #(.BAR_SIZE_LOG2(BAR_SIZE_LOG2)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_addr_i(cfg_addr_i),
  .cmd_i     (cmd_i),
  .irdy_ni   (irdy_ni),
  .trdy_ni   (trdy_ni),
  .rdata_o   (rdata_o),
  .cmd_word  (cmd_word),
  .bar_word  (bar_word),
  .int_line  (int_line)
);

// File: tb/sim_pci_cfg_space.sv
`timescale 1ns/1ps
module sim_pci_cfg_space;
  localparam int unsigned NB = 12;
  localparam logic [31:0] ID_W  = 32'h3C4D_1A2B;
  localparam logic [31:0] CLS_W = 32'h1180_0005;
  localparam logic [31:0] HDR_W = 32'h0000_0000;
  localparam logic [31:0] SUB_W = 32'h0101_1A2B;
  localparam logic [23:0] INT_HI = 24'h04_02_01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  cmd = 4'h0;
  logic [3:0]  be_n = 4'hF;
  logic        irdy_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_cmd, m_bar;
  logic [7:0]  m_il;

  always #10 clk = ~clk;

  pci_cfg_space #(.BAR_SIZE_LOG2(NB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_addr_i(addr), .cmd_i(cmd), .be_ni(be_n),
    .irdy_ni(irdy_n), .trdy_ni(trdy_n), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a[7:2])
      6'h00:   return ID_W;
      6'h01:   return m_cmd;
      6'h02:   return CLS_W;
      6'h03:   return HDR_W;
      6'h04:   return m_bar;
      6'h0B:   return SUB_W;
      6'h0F:   return {INT_HI, m_il};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] ben);
    return {{8{~ben[3]}}, {8{~ben[2]}}, {8{~ben[1]}}, {8{~ben[0]}}};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [3:0] c, input logic [7:0] a, input logic [3:0] b,
                           input logic [31:0] d, input logic ir, input logic tr);
    logic [31:0] m;
    @(negedge clk);
    cmd = c; addr = a; be_n = b; wdata = d; irdy_n = ir; trdy_n = tr;
    @(posedge clk);
    if (c == 4'b1011 && !ir && !tr) begin
      m = lane_mask(b);
      case (a)
        8'h04: m_cmd = ((m_cmd & ~m) | (d & m)) & 32'h42;
        8'h10: m_bar = ((m_bar & ~m) | (d & m)) & (32'hFFFF_FFFF << NB);
        8'h3C: if (!b[0]) m_il = d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] a);
    @(negedge clk);
    cmd = 4'b1010; addr = a; irdy_n = 1'b1; trdy_n = 1'b1; be_n = 4'h0;
    #2;
    check(req, rdata, exp_read(a));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] ofs [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                             8'h28, 8'h2C, 8'h30, 8'h3C, 8'h40, 8'hFC};
    void'($urandom(32'd7411));
    m_cmd = '0; m_bar = '0; m_il = '0;
    repeat (3) @(posedge clk);
    // R1: state zero after reset
    @(negedge clk);
    cmd = 4'b1010; addr = 8'h04; #2 check("R1", rdata, 32'h0);
    addr = 8'h10; #2 check("R1", rdata, 32'h0);
    addr = 8'h3C; #2 check("R1", rdata, {INT_HI, 8'h00});
    rst_n = 1'b1;

    // R8: identity words
    read_chk("R8", 8'h00);
    read_chk("R8", 8'h08);
    read_chk("R8", 8'h0C);
    read_chk("R8", 8'h2C);

    // R6: all-ones BAR write, low bits forced zero
    bar_cycle_all: bus_cycle(4'b1011, 8'h10, 4'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    read_chk("R6", 8'h10);
    check("R6", m_bar, 32'hFFFF_F000);

    // R5: command keeps bits 1 and 6 only
    bus_cycle(4'b1011, 8'h04, 4'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    read_chk("R5", 8'h04);
    check("R5", m_cmd, 32'h42);

    // R7: pin byte not writable
    bus_cycle(4'b1011, 8'h3C, 4'h0, 32'hAABB_CC5A, 1'b0, 1'b0);
    read_chk("R7", 8'h3C);
    check("R7", m_il, 8'h5A);

    // R4: only lane 2 of the BAR changes
    bus_cycle(4'b1011, 8'h10, 4'b1011, 32'h0000_0000, 1'b0, 1'b0);
    read_chk("R4", 8'h10);
    check("R4", m_bar, 32'hFF00_F000);

    // R3: handshake incomplete, or a memory write, leaves state alone
    bus_cycle(4'b1011, 8'h10, 4'h0, 32'h1234_5678, 1'b1, 1'b0);
    read_chk("R3", 8'h10);
    bus_cycle(4'b1011, 8'h3C, 4'h0, 32'h0000_0011, 1'b0, 1'b1);
    read_chk("R3", 8'h3C);
    bus_cycle(4'b0111, 8'h04, 4'h0, 32'h0, 1'b0, 1'b0);
    read_chk("R3", 8'h04);

    // R9: write to unimplemented offset, reads zero
    bus_cycle(4'b1011, 8'h14, 4'h0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    read_chk("R9", 8'h14);
    read_chk("R9", 8'h10);
    read_chk("R9", 8'h04);

    // R2: non-read commands give zero
    for (int c = 0; c < 16; c++) begin
      if (c != 10) begin
        @(negedge clk);
        cmd = c[3:0]; addr = 8'h00; irdy_n = 1'b1; trdy_n = 1'b1;
        #2 check("R2", rdata, 32'h0);
      end
    end

    // random mix: R3/R4 gating, R5/R6/R7/R9 readback
    for (int i = 0; i < 600; i++) begin
      logic [3:0] c;
      logic [7:0] a;
      c = ($urandom % 4 != 0) ? 4'b1011 : 4'($urandom);
      a = ($urandom % 4 != 0) ? ofs[$urandom % 12] : 8'($urandom) & 8'hFC;
      bus_cycle(c, a, 4'($urandom), $urandom, 1'($urandom % 3 == 0), 1'($urandom % 3 == 0));
      read_chk("R3", ofs[$urandom % 12]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule